// File: doc/BRIEF.md
# Glitch-Filtered Power-Fail Interrupt Pulser

This block turns a sampled comparator flag into an active-low early-warning interrupt for a processor. A periodic sample tick, roughly every 33 µs, strobes the below-threshold flag. Only a run of consecutive low samples fires the interrupt, so short dips and supply noise never reach the processor. The interrupt then lasts a bounded number of ticks. It ends early if the monitored input recovers first.

Two other events can start a pulse without the sample run. The first is the main supply dropping out of tolerance while the block is in volatile-processor mode. The second is a falling edge on the watchdog strobe line while the monitored input is already low. Until the main supply first reaches tolerance after reset, no pulse can start. When the supply falls below the battery level, the interrupt line is driven inactive. In volatile-processor mode it is also released to high impedance.

Top module: `pf_irq_pulser`

## Requirements
- R1: After reset, `irq_no` is 1 and `irq_oe_o` is 1 (with `above_bat_i` = 1).
- R2: A tick with `below_i` = 1 counts one low sample, and a tick with `below_i` = 0 clears the count. `irq_no` goes to 0 on the clock edge of the tick that carries the QUAL_SAMPLES-th consecutive low sample. Fewer consecutive low samples leave it at 1.
- R3: With `below_i` held at 1, a pulse started by samples returns `irq_no` to 1 on the PULSE_TICKS-th tick after the tick that started it.
- R4: A pulse started by samples or by the strobe ends on the first tick with `below_i` = 0, even if its full width has not elapsed.
- R5: No pulse starts while `supply_ok_i` has not yet been 1 since reset. Low samples taken during that time still count. If the count is already full, the first low-sample tick after the supply is seen fires the pulse.
- R6: After a sample-started pulse, further low samples cannot fire again until a tick samples `below_i` = 0.
- R7: A falling edge on `supply_ok_i` with `batt_mode_i` = 0 starts a pulse of full PULSE_TICKS width, whatever the value of `below_i`. With `batt_mode_i` = 1 the same edge starts no pulse.
- R8: A falling edge on `strobe_i` while `below_i` = 1, the supply has been seen and no pulse is active drives `irq_no` to 0 on the next clock edge. This needs no sample qualification.
- R9: While `above_bat_i` = 0, `irq_no` is 1. In that state `irq_oe_o` is 0 when `batt_mode_i` = 0 and 1 when `batt_mode_i` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| tick_i | input | 1 | one-cycle sample strobe |
| below_i | input | 1 | monitored input is below its threshold |
| supply_ok_i | input | 1 | main supply within tolerance |
| above_bat_i | input | 1 | main supply above battery level |
| batt_mode_i | input | 1 | 1 = battery-backed processor, 0 = volatile processor |
| strobe_i | input | 1 | watchdog strobe line (falling edge triggers) |
| irq_no | output | 1 | interrupt, active low |
| irq_oe_o | output | 1 | output enable for the interrupt driver |

## Verification
The bench builds the block with QUAL_SAMPLES = 3 and PULSE_TICKS = 4, and applies a tick every four clocks. With a short width, a full-length pulse, an early end and a blocked retrigger all fit inside a few dozen ticks. With a short qualifier, randomly biased low runs often land exactly on the firing count, and also fall one sample short of it. Random strobe edges that arrive during active pulses, and random runs that straddle the no-retrigger window, are set against a tick-level model.

// File: rtl/pf_irq_pkg.sv
package pf_irq_pkg;
  typedef enum logic {
    SRC_CMP    = 1'b0,
    SRC_SUPPLY = 1'b1
  } pf_src_e;
endpackage

// File: rtl/pf_sample_qual.sv
module pf_sample_qual #(
  parameter int unsigned QUAL_SAMPLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic below_i,
  input  logic enable_i,
  output logic fire_o
);
  localparam int unsigned CW = $clog2(QUAL_SAMPLES + 1);
  localparam logic [CW-1:0] CMAX = CW'(QUAL_SAMPLES);
  localparam logic [CW-1:0] CFIRE = CW'(QUAL_SAMPLES - 1);

  logic [CW-1:0] cnt_q;
  logic          fired_q;

  assign fire_o = tick_i & below_i & (cnt_q >= CFIRE) & ~fired_q & enable_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (tick_i) begin
      if (!below_i) begin
        cnt_q   <= '0;
        fired_q <= 1'b0;
      end else begin
        if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
        if (fire_o) fired_q <= 1'b1;
      end
    end
  end

  a_r2_clear_on_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !below_i) |=> (cnt_q == '0));
  a_r6_no_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fired_q && !(tick_i && !below_i)) |=> fired_q);
endmodule

// File: rtl/pf_pulse_timer.sv
module pf_pulse_timer
  import pf_irq_pkg::*;
#(
  parameter int unsigned PULSE_TICKS = 7
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    tick_i,
  input  logic    below_i,
  input  logic    start_i,
  input  pf_src_e src_i,
  output logic    active_o
);
  localparam int unsigned PW = $clog2(PULSE_TICKS + 1);
  localparam logic [PW-1:0] PLOAD = PW'(PULSE_TICKS);

  logic [PW-1:0] left_q;
  pf_src_e       src_q;
  logic          active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      left_q   <= '0;
      src_q    <= SRC_CMP;
    end else if (active_q) begin
      if (tick_i) begin
        if (src_q == SRC_CMP && !below_i) active_q <= 1'b0;  // input recovered
        else if (left_q == PW'(1))        active_q <= 1'b0;
        else                              left_q   <= left_q - 1'b1;
      end
    end else if (start_i) begin
      active_q <= 1'b1;
      left_q   <= PLOAD;
      src_q    <= src_i;
    end
  end

  assign active_o = active_q;

  a_r3_left_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (left_q != '0 && left_q <= PLOAD));
  a_r3_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !tick_i) |=> active_q);
endmodule

// File: rtl/pf_irq_pulser.sv
module pf_irq_pulser
  import pf_irq_pkg::*;
#(
  parameter int unsigned QUAL_SAMPLES = 3,
  parameter int unsigned PULSE_TICKS  = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic below_i,
  input  logic supply_ok_i,
  input  logic above_bat_i,
  input  logic batt_mode_i,
  input  logic strobe_i,
  output logic irq_no,
  output logic irq_oe_o
);
  logic seen_q, sup_q, strb_q;
  logic qual_fire, strb_fall, sup_fall, start, active;
  pf_src_e start_src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      sup_q  <= 1'b0;
      strb_q <= 1'b0;
    end else begin
      seen_q <= seen_q | supply_ok_i;
      sup_q  <= supply_ok_i;
      strb_q <= strobe_i;
    end
  end

  pf_sample_qual #(.QUAL_SAMPLES(QUAL_SAMPLES)) u_qual (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .below_i (below_i),
    .enable_i(seen_q),
    .fire_o  (qual_fire)
  );

  assign strb_fall = strb_q & ~strobe_i & below_i & seen_q;
  assign sup_fall  = sup_q & ~supply_ok_i & ~batt_mode_i;
  assign start     = qual_fire | strb_fall | sup_fall;
  assign start_src = sup_fall ? SRC_SUPPLY : SRC_CMP;

  pf_pulse_timer #(.PULSE_TICKS(PULSE_TICKS)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .below_i (below_i),
    .start_i (start),
    .src_i   (start_src),
    .active_o(active)
  );

  assign irq_no   = ~(active & above_bat_i);
  assign irq_oe_o = above_bat_i | batt_mode_i;

  a_r5_masked_until_supply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seen_q && !active) |=> !active);
  a_r9_idle_below_bat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !above_bat_i |-> irq_no);
endmodule

// File: tb/pf_irq_pulser_tb_top.sv
module pf_irq_pulser_tb_top;
  localparam int Q = 3;
  localparam int P = 4;

  logic clk = 0, rst_n = 0;
  logic tick = 0, below = 0, sup = 0, abat = 1, bmode = 0, strb = 0;
  logic irq_n, oe;
  int total = 0, bad = 0;
  bit done = 0;

  // tick-level model
  int  m_cnt = 0, m_left = 0;
  bit  m_fired = 0, m_act = 0, m_cmp = 1, m_seen = 0, m_supq = 0;

  always #10 clk = ~clk;

  pf_irq_pulser #(.QUAL_SAMPLES(Q), .PULSE_TICKS(P)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .below_i(below),
    .supply_ok_i(sup), .above_bat_i(abat), .batt_mode_i(bmode),
    .strobe_i(strb), .irq_no(irq_n), .irq_oe_o(oe)
  );

  function automatic bit exp_irq_n();
    return !(m_act && abat);
  endfunction

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic start_pulse(bit cmp);
    m_act = 1; m_left = P; m_cmp = cmp;
  endtask

  task automatic step(bit b, string req);
    bit q;
    @(negedge clk); below = b; tick = 1;
    @(posedge clk);
    q = b && (m_cnt >= Q - 1) && !m_fired && m_seen;
    if (m_act) begin
      if (m_cmp && !b) m_act = 0;
      else if (m_left == 1) m_act = 0;
      else m_left--;
    end else if (q) start_pulse(1);
    if (!b) m_fired = 0; else if (q) m_fired = 1;
    if (b) m_cnt = (m_cnt < Q) ? m_cnt + 1 : Q; else m_cnt = 0;
    @(negedge clk); tick = 0;
    check(req, irq_n, exp_irq_n());
    repeat (2) @(negedge clk);
  endtask

  task automatic set_sup(bit v, string req);
    @(negedge clk); sup = v;
    @(posedge clk);
    if (m_supq && !v && !bmode && !m_act) start_pulse(0);
    m_seen = m_seen | v; m_supq = v;
    @(negedge clk);
    check(req, irq_n, exp_irq_n());
  endtask

  task automatic strobe(string req);
    @(negedge clk); strb = 1;
    @(negedge clk); strb = 0;
    @(posedge clk);
    if (below && m_seen && !m_act) start_pulse(1);
    @(negedge clk);
    check(req, irq_n, exp_irq_n());
  endtask

  initial begin
    #4_000_000;
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R1 irq", irq_n, 1'b1);
    check("R1 oe", oe, 1'b1);
    rst_n = 1;
    // R5: masked during power-up
    for (int i = 0; i < 5; i++) step(1, "R5 masked");
    set_sup(1, "R5 supply up");
    step(1, "R5 fires after supply");
    check("R5 low", irq_n, 1'b0);
    // R3: full width with input held low
    for (int i = 0; i < P - 1; i++) step(1, "R3 still active");
    check("R3 before end", irq_n, 1'b0);
    step(1, "R3 end of width");
    check("R3 ended", irq_n, 1'b1);
    // R6: no retrigger while low
    for (int i = 0; i < 5; i++) step(1, "R6 no retrigger");
    // R2: short runs do not fire, exact count fires
    step(0, "R2 clear"); step(1, "R2 one"); step(1, "R2 two"); step(0, "R2 reset");
    step(1, "R2 one"); step(1, "R2 two");
    step(1, "R2 third fires");
    check("R2 low", irq_n, 1'b0);
    // R4: early end
    step(0, "R4 early end");
    check("R4 high", irq_n, 1'b1);
    // R8: strobe while below
    step(1, "R8 prep");
    strobe("R8 strobe fires");
    check("R8 low", irq_n, 1'b0);
    step(0, "R4 strobe pulse ends early");
    // R7: supply fall in volatile mode, input high
    bmode = 0;
    set_sup(0, "R7 supply fall volatile");
    check("R7 low", irq_n, 1'b0);
    step(0, "R7 not cut by high input");
    check("R7 held", irq_n, 1'b0);
    for (int i = 0; i < P - 1; i++) step(0, "R7 width");
    check("R7 ended", irq_n, 1'b1);
    set_sup(1, "R7 supply up");
    bmode = 1;
    set_sup(0, "R7 battery mode no pulse");
    check("R7 bm high", irq_n, 1'b1);
    set_sup(1, "R7 supply up again");
    // R9
    bmode = 0;
    step(1, "R9 prep"); step(1, "R9 prep");
    step(1, "R9 prep");
    @(negedge clk); abat = 0; #1;
    check("R9 forced high", irq_n, 1'b1);
    check("R9 oe volatile", oe, 1'b0);
    bmode = 1; #1;
    check("R9 oe battery", oe, 1'b1);
    abat = 1; bmode = 0;
    step(0, "R9 recover");
    // random phase against the model
    for (int i = 0; i < 600; i++) begin
      bit b;
      b = ($urandom % 4) != 0;
      if (($urandom % 16) == 0) strobe("R8 random strobe");
      else step(b, "R2 random sample");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule